// File: doc/BRIEF.md
# Parallel Pin Capture Sampler

This block is a passive, input-only observer of an eight-line bus. Eight pin inputs are first re-timed by a two-stage synchronizer. While capture is enabled, all eight bits are recorded together as one byte on each sample tick, and a programmable divider sets how often a tick occurs. The block never drives the pins, so it can watch traffic that other logic is generating on the same wires.

The sampler never waits for anything downstream. Each byte goes into a small receive FIFO. If the FIFO is full, the byte is dropped and counted, and sampling continues. A drain engine moves one FIFO entry per granted cycle into a circular capture memory. That memory has separate write and read pointers and never overwrites unread data. A host read port removes the oldest unread byte on request, and it works regardless of the enable, so the host can empty the memory while capture is still running. High sample rates suit short bursts. Sustained capture needs a rate the host can keep up with.

Top module: `pin_capture_sampler`

## Requirements
- R1: While `en` is high, a sample is taken on the first clock edge that sees `en` high and then on every (`div`+1)-th edge after it. `div` = 0 samples on every edge.
- R2: Each sample is one byte, and bit i is pin i. Pins pass through two flops first, so a pin value applied just before edge k is first recorded by the sample taken at edge k+2.
- R3: Samples enter a FIFO of FIFO_DEPTH entries (default 4). A sample whose tick arrives while the FIFO holds FIFO_DEPTH entries is discarded, even if a drain happens at the same edge, and sampling continues.
- R4: Each FIFO discard increments `fifo_drops`, which saturates at 2^CNT_W-1 (default 15), and sets the sticky flag `ovf`.
- R5: The edge that first sees `en` high clears `ovf`, `fifo_drops` and `ring_drops`.
- R6: On each edge with `drain_ok` high and the FIFO non-empty, the oldest FIFO entry leaves the FIFO. It is written to the ring memory (RING_DEPTH entries, default 16) if the ring holds fewer than RING_DEPTH entries. Otherwise it is discarded and `ring_drops` increments, saturating at 2^CNT_W-1. Unread ring entries are never overwritten.
- R7: `rd_data` shows the oldest unread ring entry and `rd_empty` is high when the ring holds none. An edge with `rd_en` high and the ring non-empty removes that entry.
- R8: `done` is low from reset and for as long as `en` is high. After `en` falls, `done` rises once the FIFO is empty, and it stays low while entries remain in the FIFO.
- R9: Samples leave through the read port in the order in which they were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Capture enable; its rising edge starts a capture |
| div | input | DIV_W | Sample interval minus one, in clock cycles |
| pins | input | PINS | Observed pin levels, asynchronous |
| drain_ok | input | 1 | Capture memory write slot granted to the drain engine |
| rd_en | input | 1 | Host pops the oldest unread sample |
| rd_data | output | PINS | Oldest unread sample |
| rd_empty | output | 1 | Capture memory holds no unread sample |
| done | output | 1 | Capture stopped and FIFO flushed |
| ovf | output | 1 | Sticky: a sample was lost at the FIFO since the last start |
| fifo_drops | output | CNT_W | Saturating count of samples lost at the FIFO |
| ring_drops | output | CNT_W | Saturating count of entries lost at the full ring |

## Verification
The assertions assume that `div` stays steady for at least one cycle before full-rate ticking is checked. They also assume that `en`, `drain_ok` and `rd_en` are synchronous to `clk`. The stimulus meets this by changing every control input only on the falling clock edge and by setting `div` before it raises `en`. The stimulus changes `pins` in mid-capture only at that same point, which gives an exact latency for the synchronizer. The FIFO depth and ring depth are assumed to be powers of two, and the defaults used by the stimulus are.

// File: rtl/pin_capture_sampler.sv
module pin_capture_sampler #(
  parameter int PINS       = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int RING_DEPTH = 16,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [PINS-1:0]  pins,
  input  logic             drain_ok,
  input  logic             rd_en,
  output logic [PINS-1:0]  rd_data,
  output logic             rd_empty,
  output logic             done,
  output logic             ovf,
  output logic [CNT_W-1:0] fifo_drops,
  output logic [CNT_W-1:0] ring_drops
);
  localparam int FA = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int RA = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [PINS-1:0]  sync1, sync2;
  logic             run_q, stopped;
  logic [DIV_W-1:0] cnt;
  logic [PINS-1:0]  fifo [FIFO_DEPTH];
  logic [FA-1:0]    fwp, frp;
  logic [FA:0]      fcnt;
  logic [PINS-1:0]  ring [RING_DEPTH];
  logic [RA-1:0]    rwp, rrp;
  logic [RA:0]      rcnt;

  wire start     = en & ~run_q;
  wire tick      = en & (cnt == '0);
  wire fifo_full = fcnt == (FA+1)'(FIFO_DEPTH);
  wire push      = tick & ~fifo_full;
  wire fdrop     = tick & fifo_full;
  wire pop       = drain_ok & (fcnt != '0);
  wire ring_full = rcnt == (RA+1)'(RING_DEPTH);
  wire rpush     = pop & ~ring_full;
  wire rdrop     = pop & ring_full;
  wire rpop      = rd_en & (rcnt != '0);

  assign rd_data  = ring[rrp];
  assign rd_empty = rcnt == '0;
  assign done     = stopped & (fcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      run_q <= 1'b0;
      stopped <= 1'b0;
      cnt <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      run_q <= en;
      if (start) stopped <= 1'b0;
      else if (!en && run_q) stopped <= 1'b1;
      cnt <= (!en || cnt >= div) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwp <= '0;
      frp <= '0;
      fcnt <= '0;
      rwp <= '0;
      rrp <= '0;
      rcnt <= '0;
    end else begin
      if (push) fwp <= fwp + 1'b1;
      if (pop) frp <= frp + 1'b1;
      fcnt <= fcnt + (FA+1)'(push) - (FA+1)'(pop);
      if (rpush) rwp <= rwp + 1'b1;
      if (rpop) rrp <= rrp + 1'b1;
      rcnt <= rcnt + (RA+1)'(rpush) - (RA+1)'(rpop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[fwp] <= sync2;
    if (rpush) ring[rwp] <= fifo[frp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      fifo_drops <= '0;
      ring_drops <= '0;
    end else if (start) begin
      ovf <= fdrop;
      fifo_drops <= CNT_W'(fdrop);
      ring_drops <= CNT_W'(rdrop);
    end else begin
      if (fdrop) ovf <= 1'b1;
      if (fdrop && fifo_drops != CMAX) fifo_drops <= fifo_drops + 1'b1;
      if (rdrop && ring_drops != CMAX) ring_drops <= ring_drops + 1'b1;
    end
  end
endmodule

module pin_capture_sampler_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int RING_DEPTH = 16,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 4,
  parameter int FW         = 3,
  parameter int RW         = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DIV_W-1:0] div,
  input logic             tick,
  input logic [FW-1:0]    fcnt,
  input logic [RW-1:0]    rcnt,
  input logic             ovf,
  input logic [CNT_W-1:0] fifo_drops,
  input logic             rd_en,
  input logic             rd_empty
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FW'(FIFO_DEPTH));

  // R6
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= RW'(RING_DEPTH));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !$rose(en)) |=> ovf);

  // R4
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fcnt == FW'(FIFO_DEPTH) && !$rose(en) && fifo_drops != CMAX)
      |=> fifo_drops == CNT_W'($past(fifo_drops) + 1'b1));

  // R1
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div == '0 && $past(div) == '0) |-> tick);

  // R7
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_empty) |=> rcnt <= $past(rcnt));
endmodule

bind pin_capture_sampler pin_capture_sampler_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .RING_DEPTH(RING_DEPTH), .DIV_W(DIV_W), .CNT_W(CNT_W),
  .FW(FA + 1), .RW(RA + 1)
) chk (
  .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tick(tick), .fcnt(fcnt),
  .rcnt(rcnt), .ovf(ovf), .fifo_drops(fifo_drops), .rd_en(rd_en), .rd_empty(rd_empty)
);

// File: tb/tb_pin_capture_sampler.sv
module tb_pin_capture_sampler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div = '0;
  logic [7:0] pins = '0;
  logic       drain_ok = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_empty, done, ovf;
  logic [3:0] fifo_drops, ring_drops;

  int checks = 0;
  int fails = 0;
  logic [7:0] got [32];
  int ngot;

  always #5 clk = ~clk;

  pin_capture_sampler dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .pins(pins), .drain_ok(drain_ok),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .done(done), .ovf(ovf),
    .fifo_drops(fifo_drops), .ring_drops(ring_drops)
  );

  localparam int NV = 4;
  localparam int TDIV [NV] = '{0, 1, 3, 2};
  localparam int TN   [NV] = '{5, 5, 8, 7};
  localparam int TPIN [NV] = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
  localparam int TEXP [NV] = '{5, 3, 2, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int d, input int n);
    @(negedge clk);
    div = 8'(d);
    en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 done low while enabled", done, 0);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_all();
    ngot = 0;
    @(negedge clk);
    while (!rd_empty && ngot < 32) begin
      got[ngot] = rd_data;
      ngot++;
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_empty == 1'b1, "R7 reset empty", rd_empty, 1);
    check(done == 1'b0, "R8 reset done", done, 0);
    check(ovf == 1'b0 && fifo_drops == 0 && ring_drops == 0, "R4 reset counters",
          {ovf, fifo_drops, ring_drops}, 0);
    rst_n = 1'b1;

    // R1 R2 R9: sample count per divider and byte value
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pins = 8'(TPIN[i]);
      repeat (3) @(negedge clk);
      capture(TDIV[i], TN[i]);
      check(done == 1'b1, "R8 done after stop", done, 1);
      check(ovf == 1'b0, "R4 no overflow", ovf, 0);
      read_all();
      check(ngot == TEXP[i], "R1 sample count", ngot, TEXP[i]);
      for (int k = 0; k < ngot; k++)
        check(got[k] == 8'(TPIN[i]), "R2 sample byte", got[k], TPIN[i]);
    end

    // R2 R9: synchronizer latency and ordering
    @(negedge clk);
    pins = 8'h11;
    repeat (3) @(negedge clk);
    div = 8'd0;
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pins = 8'hEE;
    repeat (5) @(posedge clk);
    @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    read_all();
    check(ngot == 6, "R2 latency count", ngot, 6);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] e;
      e = (k < 3) ? 8'h11 : 8'hEE;
      check(got[k] == e, "R9 order after sync", got[k], e);
    end

    // R3 R4 R8: FIFO full with the drain engine stalled
    @(negedge clk);
    pins = 8'h5A;
    drain_ok = 1'b0;
    repeat (3) @(negedge clk);
    capture(0, 6);
    check(fifo_drops == 4'd2, "R4 fifo drop count", fifo_drops, 2);
    check(ovf == 1'b1, "R4 overflow flag", ovf, 1);
    check(done == 1'b0, "R8 done waits for flush", done, 0);
    check(rd_empty == 1'b1, "R6 nothing drained", rd_empty, 1);
    drain_ok = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8 done after flush", done, 1);
    check(ovf == 1'b1, "R4 flag sticky after stop", ovf, 1);
    read_all();
    check(ngot == 4, "R3 fifo kept depth", ngot, 4);

    // R5 R6: ring full drops, start clears overflow
    @(negedge clk);
    pins = 8'hC3;
    repeat (3) @(negedge clk);
    capture(0, 20);
    check(ovf == 1'b0, "R5 start clears flag", ovf, 0);
    check(fifo_drops == 4'd0, "R5 start clears fifo drops", fifo_drops, 0);
    check(ring_drops == 4'd4, "R6 ring drop count", ring_drops, 4);
    read_all();
    check(ngot == 16, "R6 ring holds depth", ngot, 16);
    check(got[0] == 8'hC3 && got[15] == 8'hC3, "R6 no overwrite", got[15], 8'hC3);

    // R4 R5: saturation of the FIFO drop counter
    @(negedge clk);
    drain_ok = 1'b0;
    capture(0, 25);
    check(fifo_drops == 4'd15, "R4 saturation", fifo_drops, 15);
    check(ring_drops == 4'd0, "R5 ring drops cleared", ring_drops, 0);
    drain_ok = 1'b1;
    repeat (5) @(negedge clk);
    read_all();
    check(ngot == 4, "R3 after saturation", ngot, 4);
    check(rd_empty == 1'b1, "R7 empty after reads", rd_empty, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule